// File: doc/BRIEF.md
# Strap-Addressed I2C Register Target

This block is an I2C target that lets a bus host read and write a small on-chip register file. Its 7-bit bus address is not fixed. It is chosen at reset from a 3-bit strap index through an eight-entry table, so that up to eight copies can share one bus. The block watches an SCL/SDA pair through synchronizers clocked by the system clock, which must run at least eight times the SCL rate. It recognises START, repeated START and STOP. It answers its own address with an ACK and keeps a register pointer that advances after each byte.

A write transfer sends the address byte with R/W=0, then one pointer byte, then any number of data bytes. A read transfer first sets the pointer with a write, then issues a repeated START and the address with R/W=1, and then clocks data out of the block. The block only ever pulls SDA low, through `sda_oe`. It never stretches the clock.

Top module: `strap_i2c_regs`

## Requirements
- R1: While `rst` is high, `sda_oe` is 0 from the next clock on. The strap index is captured on the last reset cycle and then held, so changes to `strap_idx` after reset have no effect on the address.
- R2: Strap index 0,1,2,3,4,5,6,7 selects bus address 0x30,0x32,0x34,0x36,0x38,0x3A,0x3C,0x3D. The R/W flag is bit 0 of the address byte (0 = write, 1 = read), and the address occupies bits 7:1, so the write bytes are 0x60 to 0x78 in steps of 4, then 0x7A.
- R3: On an address match the block pulls SDA low during the ninth SCL pulse (ACK). On a mismatch it leaves SDA released (NACK) and ignores every later byte, including writes, until the next START.
- R4: A START or repeated START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. A STOP releases SDA and idles the block.
- R5: In a write, the first byte after the address loads the pointer from its low REG_AW bits. Each later byte is stored at the pointer, the pointer then increments, and every such byte is ACKed.
- R6: After a matched address with R/W=1, the block sends the register at the pointer MSB first and increments the pointer after each byte.
- R7: A host ACK (SDA low on the ninth pulse) after a read byte starts the next byte. A host NACK makes the block stop driving SDA until the next START or STOP.
- R8: `sda_oe` only rises while SCL is low, so driven data and ACK are stable across each SCL high phase.
- R9: A START that arrives inside a byte abandons the partial byte without storing it and restarts with address reception at bit 0.
- R10: The pointer wraps from the last register (2**REG_AW-1) to register 0 for both writes and reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| strap_idx | input | 3 | Address strap index, captured at reset release |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench walks all eight strap settings. A wrong table entry or an off-by-one offset shows up as a missing ACK or a stray ACK on the neighbouring address. Write-then-read vectors include one that crosses the top register, so a pointer that saturates instead of wrapping returns the wrong second byte. The bench also probes misaddressed writes, which must leave memory unchanged, and a host NACK, after which a block that keeps driving would return data instead of 0xFF. It sends a START in the middle of a data byte: a block that does not reset its bit counter would miss the following address, and one that stores the fragment would corrupt the register.

// File: rtl/strap_i2c_pkg.sv
package strap_i2c_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_HACK,
    ST_WAIT
  } state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } phase_t;

  // Strap index to 7-bit bus address: even steps from 0x30, last slot 0x3D.
  function automatic logic [6:0] strap_to_addr(input logic [2:0] idx);
    if (idx == 3'd7) return 7'h3D;
    return 7'h30 + {3'b000, idx, 1'b0};
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[l]};
    end
    assign synced[l] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= synced;
  end

  logic scl_s;
  assign scl_s     = synced[0];
  assign sda_s     = synced[1];
  assign scl_rise  = scl_s & ~prev[0];
  assign scl_fall  = ~scl_s & prev[0];
  assign start_det = scl_s & prev[0] & prev[1] & ~sda_s;
  assign stop_det  = scl_s & prev[0] & ~prev[1] & sda_s;

endmodule

// File: rtl/i2c_regfile.sv
module i2c_regfile #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/strap_i2c_regs.sv
module strap_i2c_regs
  import strap_i2c_pkg::*;
#(
  parameter int REG_AW      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] strap_idx,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  logic [2:0] strap_q;
  logic [6:0] dev_addr;

  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_idx;
  end
  assign dev_addr = strap_to_addr(strap_q);

  state_t             state;
  phase_t             phase;
  logic [CNT_W-1:0]   cnt;
  logic [BYTE_W-1:0]  rx_sh;
  logic [BYTE_W-1:0]  tx_sh;
  logic               byte_done;
  logic               rd_mode;
  logic               more;
  logic [REG_AW-1:0]  ptr;
  logic [BYTE_W-1:0]  rdata;
  logic               wr_en;

  assign wr_en = (state == ST_RX) && scl_fall && byte_done && (phase == PH_DATA)
                 && !start_det && !stop_det;

  i2c_regfile #(.AW(REG_AW), .DW(BYTE_W)) u_rf (
    .clk   (clk),
    .we    (wr_en),
    .waddr (ptr),
    .wdata (rx_sh),
    .raddr (ptr),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      phase     <= PH_ADDR;
      cnt       <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      byte_done <= 1'b0;
      rd_mode   <= 1'b0;
      more      <= 1'b0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
    end else if (start_det) begin
      state     <= ST_RX;
      phase     <= PH_ADDR;
      cnt       <= '0;
      byte_done <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (stop_det) begin
      state     <= ST_IDLE;
      byte_done <= 1'b0;
      sda_oe    <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise) begin
            rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_BIT) byte_done <= 1'b1;
          end else if (scl_fall && byte_done) begin
            byte_done <= 1'b0;
            cnt       <= '0;
            case (phase)
              PH_ADDR: begin
                if (rx_sh[7:1] == dev_addr) begin
                  sda_oe  <= 1'b1;
                  state   <= ST_ACK;
                  rd_mode <= rx_sh[0];
                  phase   <= PH_PTR;
                end else begin
                  state <= ST_WAIT;
                end
              end
              PH_PTR: begin
                ptr    <= rx_sh[REG_AW-1:0];
                phase  <= PH_DATA;
                sda_oe <= 1'b1;
                state  <= ST_ACK;
              end
              default: begin
                ptr    <= ptr + 1'b1;
                sda_oe <= 1'b1;
                state  <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rd_mode) begin
              tx_sh  <= rdata;
              sda_oe <= ~rdata[BYTE_W-1];
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              ptr    <= ptr + 1'b1;
              state  <= ST_HACK;
            end else begin
              cnt    <= cnt + 1'b1;
              tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx_sh[BYTE_W-2];
            end
          end
        end
        ST_HACK: begin
          if (scl_rise) begin
            more <= ~sda_s;
          end else if (scl_fall) begin
            if (more) begin
              tx_sh  <= rdata;
              sda_oe <= ~rdata[BYTE_W-1];
              cnt    <= '0;
              state  <= ST_TX;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/strap_i2c_regs_chk.sv
module strap_i2c_regs_chk
  import strap_i2c_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       start_det,
  input logic       stop_det,
  input state_t     state,
  input logic [2:0] strap_q
);

  // R1
  reset_release_chk: assert property (@(posedge clk) rst |=> !sda_oe);

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(strap_q));

  // R8
  drive_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  // R4
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det && !start_det |=> (state == ST_IDLE) && !sda_oe);

  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_RX) && !sda_oe);

  // R7
  drive_state_chk: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (state == ST_ACK || state == ST_TX));

endmodule

bind strap_i2c_regs strap_i2c_regs_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe),
  .start_det (start_det),
  .stop_det  (stop_det),
  .state     (state),
  .strap_q   (strap_q)
);

// File: tb/sim_strap_i2c_regs.sv
`timescale 1ns/1ps
module sim_strap_i2c_regs;

  localparam int Q = 4;
  localparam logic [6:0] ADDR_TBL [8] = '{7'h30, 7'h32, 7'h34, 7'h36,
                                          7'h38, 7'h3A, 7'h3C, 7'h3D};
  // {pointer, first byte, second byte}
  localparam logic [23:0] VEC [8] = '{24'h00A55A, 24'h03FF00, 24'h07817E,
                                      24'h0FC33C, 24'h0A0180, 24'h053FF0,
                                      24'h0E55AA, 24'h091234};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] strap = 3'd0;
  logic host_scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_oe;
  wire  sda_line = host_sda & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  strap_i2c_regs u0 (
    .clk       (clk),
    .rst       (rst),
    .strap_idx (strap),
    .scl_i     (host_scl),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] s);
    rst = 1'b1; strap = s; host_scl = 1'b1; host_sda = 1'b1;
    tick(4);
    rst = 1'b0;
    tick(4);
  endtask

  task automatic bit_x(input logic b, output logic r);
    host_sda = b; tick(Q);
    host_scl = 1'b1; tick(Q);
    r = sda_line; tick(Q);
    host_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; tick(Q);
    host_scl = 1'b1; tick(Q);
    host_sda = 1'b0; tick(Q);
    host_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; tick(Q);
    host_scl = 1'b1; tick(Q);
    host_sda = 1'b1; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(b[i], r);
    bit_x(1'b1, r);
    ack = !r;
  endtask

  task automatic rd_byte(input logic nack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, r);
      d[i] = r;
    end
    bit_x(nack, r);
  endtask

  task automatic reg_write(input logic [6:0] a, input logic [7:0] p,
                           input logic [7:0] d, output logic ok);
    logic k0, k1, k2;
    bus_start();
    wr_byte({a, 1'b0}, k0);
    wr_byte(p, k1);
    wr_byte(d, k2);
    bus_stop();
    ok = k0 & k1 & k2;
  endtask

  task automatic reg_read(input logic [6:0] a, input logic [7:0] p,
                          output logic [7:0] d, output logic ok);
    logic k0, k1, k2;
    bus_start();
    wr_byte({a, 1'b0}, k0);
    wr_byte(p, k1);
    bus_start();
    wr_byte({a, 1'b1}, k2);
    rd_byte(1'b1, d);
    bus_stop();
    ok = k0 & k1 & k2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ack, ok;
    logic [7:0] d0, d1;
    logic [6:0] a;

    // R1: reset state
    do_reset(3'd3);
    check(sda_oe == 1'b0 && sda_line == 1'b1, "R1 reset release", {15'h0, sda_oe}, 16'h0);

    // Table walk: one loop over write/read vectors at strap 3 (address 0x36)
    a = ADDR_TBL[3];
    for (int v = 0; v < 8; v++) begin
      logic k0, k1, k2, k3, k4, k5;
      bus_start();
      wr_byte({a, 1'b0}, k0);
      wr_byte(VEC[v][23:16], k1);
      wr_byte(VEC[v][15:8], k2);
      wr_byte(VEC[v][7:0], k3);
      bus_stop();
      // R5: address, pointer and both data bytes acknowledged
      check(k0 & k1 & k2 & k3, "R5 write acks", {12'h0, k0, k1, k2, k3}, 16'h000F);
      bus_start();
      wr_byte({a, 1'b0}, k4);
      wr_byte(VEC[v][23:16], k5);
      bus_start();
      wr_byte({a, 1'b1}, k4);
      rd_byte(1'b0, d0);
      rd_byte(1'b1, d1);
      bus_stop();
      // R6, R8: MSB-first readback of the pointed register
      check(d0 == VEC[v][15:8], "R6 first read byte", {8'h0, d0}, {8'h0, VEC[v][15:8]});
      // R7 host ACK continues; R10 pointer wrap on vector at 0x0F
      check(d1 == VEC[v][7:0], "R7/R10 second read byte", {8'h0, d1}, {8'h0, VEC[v][7:0]});
    end

    // R2: each strap value answers only its table address
    for (int s = 0; s < 8; s++) begin
      logic [6:0] other;
      do_reset(3'(s));
      bus_start();
      wr_byte({ADDR_TBL[s], 1'b0}, ack);
      bus_stop();
      check(ack, "R2 own address ack", {15'h0, ack}, 16'h1);
      other = (s == 7) ? 7'h3C : ADDR_TBL[s] + 7'd1;
      bus_start();
      wr_byte({other, 1'b0}, ack);
      bus_stop();
      check(!ack, "R2 neighbour address nack", {15'h0, ack}, 16'h0);
    end

    // R1: strap changes after reset are ignored
    do_reset(3'd2);
    strap = 3'd5;
    tick(8);
    bus_start();
    wr_byte({ADDR_TBL[2], 1'b0}, ack);
    bus_stop();
    check(ack, "R1 latched strap still answers", {15'h0, ack}, 16'h1);
    bus_start();
    wr_byte({ADDR_TBL[5], 1'b0}, ack);
    bus_stop();
    check(!ack, "R1 new strap ignored", {15'h0, ack}, 16'h0);

    // R3: misaddressed transfer is nacked and does not write
    a = ADDR_TBL[2];
    reg_write(a, 8'h04, 8'h11, ok);
    check(ok, "R5 setup write", {15'h0, ok}, 16'h1);
    begin
      logic k0, k1, k2;
      bus_start();
      wr_byte({7'h35, 1'b0}, k0);
      wr_byte(8'h04, k1);
      wr_byte(8'h99, k2);
      bus_stop();
      check(!(k0 | k1 | k2), "R3 mismatch nacks", {13'h0, k0, k1, k2}, 16'h0);
    end
    reg_read(a, 8'h04, d0, ok);
    check(ok && d0 == 8'h11, "R3 ignored write", {8'h0, d0}, 16'h0011);

    // R7: after host NACK the block no longer drives data
    reg_write(a, 8'h02, 8'h00, ok);
    bus_start();
    wr_byte({a, 1'b0}, ack);
    wr_byte(8'h02, ack);
    bus_start();
    wr_byte({a, 1'b1}, ack);
    rd_byte(1'b1, d0);
    rd_byte(1'b1, d1);
    bus_stop();
    check(d0 == 8'h00, "R7 byte before nack", {8'h0, d0}, 16'h0000);
    check(d1 == 8'hFF, "R7 released after nack", {8'h0, d1}, 16'h00FF);

    // R9: START inside a data byte aborts it and restarts addressing
    reg_write(a, 8'h06, 8'h22, ok);
    begin
      logic r, k0, k1;
      bus_start();
      wr_byte({a, 1'b0}, k0);
      wr_byte(8'h06, k1);
      for (int i = 0; i < 4; i++) bit_x(1'b1, r);
      bus_start();
      wr_byte({a, 1'b0}, ack);
      check(ack, "R9 address after abort", {15'h0, ack}, 16'h1);
      wr_byte(8'h06, k1);
      bus_start();
      wr_byte({a, 1'b1}, k0);
      rd_byte(1'b1, d0);
      bus_stop();
      check(d0 == 8'h22, "R9 partial byte not stored", {8'h0, d0}, 16'h0022);
    end

    // R4: STOP leaves the bus released and the block idle
    tick(8);
    check(sda_oe == 1'b0, "R4 released after stop", {15'h0, sda_oe}, 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule